// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

A small processor-side cache for a 16-bit byte-addressed memory space. It holds 256 lines of 8 bytes each; every line has one location only, picked by the middle address bits. The processor issues one request at a time: a read or a write of a 16-bit word with per-byte enables. The cache answers each accepted request with a single response pulse that carries the read data and whether the lookup hit.

A read that misses fetches the whole 8-byte line over a line-wide read port. The port uses a request/ready handshake. The cache then installs the line, and the requested word comes back with the response. Every write is forwarded toward memory through a four-entry FIFO. The FIFO drains on its own over a word-wide write port, so the processor does not wait for memory on a write. A write that hits also updates the cached line. A write that misses leaves the cache contents unchanged.

Top module: `dm_wt_cache`

## Requirements
- R1: The address is decoded as tag = addr[15:11], line index = addr[10:3], word select = addr[2:1]. addr[0] is ignored, and word w of a line occupies line bits [16w+15:16w].
- R2: After reset every line is invalid: the first read of any address is a miss. cpu_ready is 1, and cpu_resp_valid, mem_rd_req and mem_wr_req are 0.
- R3: A request is accepted in a cycle where cpu_req and cpu_ready are both 1. A hit, or any write, is answered by a one-cycle cpu_resp_valid pulse exactly two clock edges after the accepting edge.
- R4: A lookup hits only when the indexed line is valid and its stored tag equals the address tag. A read to the same index with another tag misses, and the new line replaces the old one.
- R5: A read miss raises mem_rd_req with mem_rd_addr = addr[15:3]. It holds both until mem_rd_ready is 1. It then returns the selected word of mem_rd_line with cpu_hit = 0, and it installs the line.
- R6: A write hit changes only the bytes whose enable is set: cpu_be[0] covers bits [7:0] and cpu_be[1] covers bits [15:8]. A later read of the word returns the merged value.
- R7: Every accepted write appears on the write port in acceptance order, with mem_wr_addr = addr[15:1] and the same data and byte enables. An entry is removed only in a cycle where mem_wr_req and mem_wr_ready are both 1.
- R8: A write miss does not allocate. A following read of that address misses and returns the written data.
- R9: The write FIFO holds 4 entries. While it is full, cpu_ready is 0.
- R10: A read miss does not raise mem_rd_req until the write FIFO is empty. mem_rd_req and mem_wr_req are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 16 | Write word |
| cpu_be | input | 2 | Byte enables for the write word |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_resp_valid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | 16 | Read word (0 for writes) |
| cpu_hit | output | 1 | Lookup hit flag for the response |
| mem_rd_req | output | 1 | Line fetch request |
| mem_rd_addr | output | 13 | Line address (tag and index) |
| mem_rd_ready | input | 1 | Line data valid, ends the fetch |
| mem_rd_line | input | 64 | Fetched line |
| mem_wr_req | output | 1 | Write FIFO head is valid |
| mem_wr_addr | output | 15 | Word address of the head write |
| mem_wr_data | output | 16 | Data of the head write |
| mem_wr_be | output | 2 | Byte enables of the head write |
| mem_wr_ready | input | 1 | Memory takes the head write |

## Verification
Directed patterns come first. A cold read separates the reset state from stale lines. A second word of the same line, read with addr[0] flipped, shows that the index and word fields are decoded as specified. A same-index read with a different tag then forces a replacement. A partial-enable write hit tells merged bytes apart from overwritten ones, and a write miss followed by a read separates no-allocate from allocate. With the write port held off, the bench fills the FIFO to expose the stall, and it blocks a fill behind a pending write so that stale-memory returns would show up. A seeded random mix then runs over few tags and indices with a stalling write port and varying fill delay, which produces hits, conflicts and back-pressure in many interleavings.

// File: rtl/dm_cache_pkg.sv
package dm_cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_DRAIN  = 2'd2,
    ST_FILL   = 2'd3
  } cache_state_t;

endpackage

// File: rtl/dm_tag_store.sv
module dm_tag_store #(
  parameter int TAG_W = 5,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_mem [SETS];
  logic [SETS-1:0]  valid_bits;

  // tag array: no reset, registered read
  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= tag_mem[rd_idx];
  end

  // valid bits live in flops so one reset clears them all
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_bits <= '0;
      rd_valid   <= 1'b0;
    end else begin
      if (wr_en) valid_bits[wr_idx] <= 1'b1;
      if (rd_en) rd_valid <= valid_bits[rd_idx];
    end
  end
endmodule

// File: rtl/dm_line_store.sv
module dm_line_store #(
  parameter int IDX_W      = 8,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rd_en,
  input  logic [IDX_W-1:0]        rd_idx,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [LINE_BYTES-1:0]   wr_be,
  input  logic [LINE_BYTES*8-1:0] wr_data,
  output logic [LINE_BYTES*8-1:0] rd_line
);
  localparam int SETS = 1 << IDX_W;

  // one narrow RAM per byte lane gives byte-enabled writes without read-modify-write
  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    logic [7:0] lane_mem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[b]) lane_mem[wr_idx] <= wr_data[b*8 +: 8];
      if (rd_en) rd_line[b*8 +: 8] <= lane_mem[rd_idx];
    end
  end
endmodule

// File: rtl/dm_write_fifo.sv
module dm_write_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic             empty,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic do_push, do_pop;
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = slots[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import dm_cache_pkg::*;
#(
  parameter int TAG_W          = 5,
  parameter int IDX_W          = 8,
  parameter int WORD_W         = 16,
  parameter int WORDS_PER_LINE = 4,
  parameter int WB_DEPTH       = 4,
  localparam int WBYTES  = WORD_W / 8,
  localparam int LBYTES  = WORDS_PER_LINE * WBYTES,
  localparam int OFF_W   = $clog2(LBYTES),
  localparam int BSEL_W  = $clog2(WBYTES),
  localparam int ADDR_W  = TAG_W + IDX_W + OFF_W,
  localparam int LADDR_W = TAG_W + IDX_W,
  localparam int WADDR_W = ADDR_W - BSEL_W,
  localparam int LINE_W  = LBYTES * 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [WORD_W-1:0]  cpu_wdata,
  input  logic [WBYTES-1:0]  cpu_be,
  output logic               cpu_ready,
  output logic               cpu_resp_valid,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               cpu_hit,
  output logic               mem_rd_req,
  output logic [LADDR_W-1:0] mem_rd_addr,
  input  logic               mem_rd_ready,
  input  logic [LINE_W-1:0]  mem_rd_line,
  output logic               mem_wr_req,
  output logic [WADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0]  mem_wr_data,
  output logic [WBYTES-1:0]  mem_wr_be,
  input  logic               mem_wr_ready
);
  localparam int WSEL_W = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1;
  localparam int WB_W   = WADDR_W + WORD_W + WBYTES;
  localparam int CNT_W  = $clog2(WB_DEPTH + 1);

  cache_state_t state;

  // captured request
  logic              req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [WORD_W-1:0] req_wdata;
  logic [WBYTES-1:0] req_be;

  logic [TAG_W-1:0]  r_tag;
  logic [IDX_W-1:0]  r_idx;
  logic [WSEL_W-1:0] r_wsel;
  assign r_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign r_idx  = req_addr[OFF_W +: IDX_W];
  assign r_wsel = WSEL_W'(req_addr[OFF_W-1:BSEL_W]);

  logic accept;
  assign accept = cpu_req && cpu_ready;

  // storage
  logic             tag_valid;
  logic [TAG_W-1:0] tag_q;
  logic [LINE_W-1:0] line_q;
  logic             fill_done;
  logic             line_wr;
  logic [LBYTES-1:0] line_be;
  logic [LINE_W-1:0] line_wdata;
  logic             hit_now;

  assign fill_done = (state == ST_FILL) && mem_rd_ready;
  assign hit_now   = tag_valid && (tag_q == r_tag);

  dm_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (accept),
    .rd_idx   (cpu_addr[OFF_W +: IDX_W]),
    .wr_en    (fill_done),
    .wr_idx   (r_idx),
    .wr_tag   (r_tag),
    .rd_valid (tag_valid),
    .rd_tag   (tag_q)
  );

  always_comb begin
    if (fill_done) begin
      line_wr    = 1'b1;
      line_be    = '1;
      line_wdata = mem_rd_line;
    end else begin
      line_wr    = (state == ST_LOOKUP) && req_we && hit_now;
      line_be    = LBYTES'(req_be) << (r_wsel * WBYTES);
      line_wdata = {WORDS_PER_LINE{req_wdata}};
    end
  end

  dm_line_store #(.IDX_W(IDX_W), .LINE_BYTES(LBYTES)) u_lines (
    .clk     (clk),
    .rd_en   (accept),
    .rd_idx  (cpu_addr[OFF_W +: IDX_W]),
    .wr_en   (line_wr),
    .wr_idx  (r_idx),
    .wr_be   (line_be),
    .wr_data (line_wdata),
    .rd_line (line_q)
  );

  // write-through posting
  logic             wb_push, wb_empty, wb_full;
  logic [WB_W-1:0]  wb_head;
  logic [CNT_W-1:0] wb_count;

  assign wb_push = (state == ST_LOOKUP) && req_we;

  dm_write_fifo #(.W(WB_W), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (wb_push),
    .push_data ({req_addr[ADDR_W-1:BSEL_W], req_wdata, req_be}),
    .pop       (mem_wr_req && mem_wr_ready),
    .head      (wb_head),
    .empty     (wb_empty),
    .full      (wb_full),
    .count     (wb_count)
  );

  assign mem_wr_req  = !wb_empty;
  assign mem_wr_addr = wb_head[WB_W-1 -: WADDR_W];
  assign mem_wr_data = wb_head[WBYTES +: WORD_W];
  assign mem_wr_be   = wb_head[WBYTES-1:0];

  assign cpu_ready = (state == ST_IDLE) && !wb_full;

  // control
  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_IDLE;
      req_we         <= 1'b0;
      req_addr       <= '0;
      req_wdata      <= '0;
      req_be         <= '0;
      cpu_resp_valid <= 1'b0;
      cpu_rdata      <= '0;
      cpu_hit        <= 1'b0;
      mem_rd_req     <= 1'b0;
      mem_rd_addr    <= '0;
    end else begin
      cpu_resp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            req_we    <= cpu_we;
            req_addr  <= cpu_addr;
            req_wdata <= cpu_wdata;
            req_be    <= cpu_be;
            state     <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (req_we) begin
            cpu_resp_valid <= 1'b1;
            cpu_hit        <= hit_now;
            cpu_rdata      <= '0;
            state          <= ST_IDLE;
          end else if (hit_now) begin
            cpu_resp_valid <= 1'b1;
            cpu_hit        <= 1'b1;
            cpu_rdata      <= line_q[r_wsel*WORD_W +: WORD_W];
            state          <= ST_IDLE;
          end else begin
            state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (wb_empty) begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= {r_tag, r_idx};
            state       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_ready) begin
            mem_rd_req     <= 1'b0;
            cpu_resp_valid <= 1'b1;
            cpu_hit        <= 1'b0;
            cpu_rdata      <= mem_rd_line[r_wsel*WORD_W +: WORD_W];
            state          <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dm_wt_cache_chk.sv
module dm_wt_cache_chk #(
  parameter int LADDR_W  = 13,
  parameter int WADDR_W  = 15,
  parameter int WORD_W   = 16,
  parameter int WB_DEPTH = 4,
  parameter int CNT_W    = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_ready,
  input logic               cpu_resp_valid,
  input logic               cpu_hit,
  input logic               mem_rd_req,
  input logic               mem_rd_ready,
  input logic [LADDR_W-1:0] mem_rd_addr,
  input logic               mem_wr_req,
  input logic               mem_wr_ready,
  input logic [WADDR_W-1:0] mem_wr_addr,
  input logic [WORD_W-1:0]  mem_wr_data,
  input logic [CNT_W-1:0]   wb_count
);
  p_one_cycle_resp_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |=> !cpu_resp_valid);

  p_fetch_held_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ready) |=> (mem_rd_req && $stable(mem_rd_addr)));

  p_fill_is_miss_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_ready) |=> (cpu_resp_valid && !cpu_hit));

  p_drain_held_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && !mem_wr_ready) |=>
      (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_full_stalls_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_count == CNT_W'(WB_DEPTH)) |-> !cpu_ready);

  p_fill_after_drain_r10: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !mem_wr_req);
endmodule

bind dm_wt_cache dm_wt_cache_chk #(
  .LADDR_W  (LADDR_W),
  .WADDR_W  (WADDR_W),
  .WORD_W   (WORD_W),
  .WB_DEPTH (WB_DEPTH),
  .CNT_W    (CNT_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cpu_ready      (cpu_ready),
  .cpu_resp_valid (cpu_resp_valid),
  .cpu_hit        (cpu_hit),
  .mem_rd_req     (mem_rd_req),
  .mem_rd_ready   (mem_rd_ready),
  .mem_rd_addr    (mem_rd_addr),
  .mem_wr_req     (mem_wr_req),
  .mem_wr_ready   (mem_wr_ready),
  .mem_wr_addr    (mem_wr_addr),
  .mem_wr_data    (mem_wr_data),
  .wb_count       (wb_count)
);

// File: tb/dm_wt_cache_tb.sv
module dm_wt_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic [1:0]  cpu_be = '0;
  logic        cpu_ready, cpu_resp_valid, cpu_hit;
  logic [15:0] cpu_rdata;
  logic        mem_rd_req, mem_rd_ready = 1'b0;
  logic [12:0] mem_rd_addr;
  logic [63:0] mem_rd_line = '0;
  logic        mem_wr_req, mem_wr_ready = 1'b0;
  logic [14:0] mem_wr_addr;
  logic [15:0] mem_wr_data;
  logic [1:0]  mem_wr_be;

  always #5 clk = ~clk;

  dm_wt_cache dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
    .cpu_ready(cpu_ready), .cpu_resp_valid(cpu_resp_valid),
    .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rd_line(mem_rd_line),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
    .mem_wr_ready(mem_wr_ready)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;
  bit hold_wr  = 1'b0;
  logic [15:0] cur_addr = '0;

  logic [7:0]  arch_m [int];
  logic [7:0]  phys_m [int];
  logic [33:0] exp_wr_q [$];
  bit          ref_v [256];
  logic [4:0]  ref_t [256];

  function automatic logic [7:0] seed_byte(input int a);
    logic [15:0] v;
    v = a[15:0];
    return v[7:0] ^ v[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [7:0] arch_rd(input int a);
    return arch_m.exists(a) ? arch_m[a] : seed_byte(a);
  endfunction

  function automatic logic [7:0] phys_rd(input int a);
    return phys_m.exists(a) ? phys_m[a] : seed_byte(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  // write port responder: random back-pressure, checks order and content (R7)
  initial begin
    forever begin
      @(negedge clk);
      mem_wr_ready = !hold_wr && ($urandom % 3 != 0);
      if (!rst && mem_wr_req && mem_wr_ready) begin
        logic [33:0] got;
        got = {mem_wr_addr, mem_wr_data, mem_wr_be};
        if (exp_wr_q.size() == 0) begin
          chk(1'b0, "R7 unexpected write", 64'(got), 64'd0);
        end else begin
          logic [33:0] e;
          e = exp_wr_q.pop_front();
          chk(got == e, "R7 drained write", 64'(got), 64'(e));
        end
        for (int b = 0; b < 2; b++)
          if (mem_wr_be[b]) phys_m[int'({mem_wr_addr, 1'b0}) + b] = mem_wr_data[b*8 +: 8];
      end
    end
  end

  // line fetch responder (R5)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_rd_req) begin
        chk(mem_rd_addr == cur_addr[15:3], "R5 fetch line address", 64'(mem_rd_addr), 64'(cur_addr[15:3]));
        repeat ($urandom % 4) @(negedge clk);
        for (int b = 0; b < 8; b++)
          mem_rd_line[b*8 +: 8] = phys_rd(int'({mem_rd_addr, 3'b000}) + b);
        mem_rd_ready = 1'b1;
        @(negedge clk);
        mem_rd_ready = 1'b0;
      end
    end
  end

  // fetch never overlaps a pending write (R10)
  always @(negedge clk) begin
    if (!rst && mem_rd_req) chk(!mem_wr_req, "R10 fetch with write pending", 64'(mem_wr_req), 64'd0);
  end

  task automatic do_req(input bit we, input logic [15:0] a, input logic [15:0] wd,
                        input logic [1:0] be, input string tag);
    bit exp_hit;
    logic [15:0] exp_rd;
    int lat;
    int base;
    logic [7:0] idx;
    idx = a[10:3];
    base = int'({a[15:1], 1'b0});
    exp_hit = ref_v[idx] && (ref_t[idx] == a[15:11]);
    exp_rd = {arch_rd(base + 1), arch_rd(base)};
    while (!cpu_ready) @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_be = be;
    cur_addr = a;
    @(posedge clk);
    if (we) begin
      exp_wr_q.push_back({a[15:1], wd, be});
      for (int b = 0; b < 2; b++)
        if (be[b]) arch_m[base + b] = wd[b*8 +: 8];
    end
    @(negedge clk);
    cpu_req = 1'b0;
    lat = 1;
    while (!cpu_resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(cpu_hit == exp_hit, {tag, " R4 hit flag"}, 64'(cpu_hit), 64'(exp_hit));
    if (!we) chk(cpu_rdata == exp_rd, {tag, " read data"}, 64'(cpu_rdata), 64'(exp_rd));
    if (exp_hit || we) chk(lat == 2, {tag, " R3 latency"}, 64'(lat), 64'd2);
    if (!we && !exp_hit) begin
      ref_v[idx] = 1'b1;
      ref_t[idx] = a[15:11];
    end
  endtask

  task automatic wait_drained();
    int t;
    hold_wr = 1'b0;
    t = 0;
    while (mem_wr_req && t < 1000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin ref_v[i] = 1'b0; ref_t[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    chk(cpu_ready == 1'b1, "R2 ready after reset", 64'(cpu_ready), 64'd1);
    chk(cpu_resp_valid == 1'b0, "R2 no response", 64'(cpu_resp_valid), 64'd0);
    chk(mem_rd_req == 1'b0, "R2 no fetch", 64'(mem_rd_req), 64'd0);
    chk(mem_wr_req == 1'b0, "R2 no write", 64'(mem_wr_req), 64'd0);

    // R2/R5 cold miss, R1 same line other word and odd byte address hits
    do_req(1'b0, 16'h1238, '0, 2'b00, "R2 R5 cold read");
    do_req(1'b0, 16'h123F, '0, 2'b00, "R1 same line word3 odd");
    // R4 same index different tag: miss and replace
    do_req(1'b0, 16'h1238 ^ 16'h0800, '0, 2'b00, "R4 conflict");
    do_req(1'b0, 16'h1238, '0, 2'b00, "R4 old line evicted");
    // R6 partial write hit, then read merged word
    do_req(1'b1, 16'h123A, 16'hA55A, 2'b01, "R6 low byte write");
    do_req(1'b0, 16'h123A, '0, 2'b00, "R6 merged read");
    do_req(1'b1, 16'h123A, 16'hC3C3, 2'b10, "R6 high byte write");
    do_req(1'b0, 16'h123B, '0, 2'b00, "R6 merged read2");
    // R8 write miss does not allocate
    do_req(1'b1, 16'h4440, 16'hBEEF, 2'b11, "R8 write miss");
    do_req(1'b0, 16'h4440, '0, 2'b00, "R8 read after write miss");

    // R9 four posted writes fill the buffer
    wait_drained();
    hold_wr = 1'b1;
    for (int k = 0; k < 4; k++)
      do_req(1'b1, 16'h6000 + 16'(k * 8), 16'(16'h1100 + k), 2'b11, "R9 fill write");
    chk(cpu_ready == 1'b0, "R9 stall when full", 64'(cpu_ready), 64'd0);
    repeat (5) @(negedge clk);
    chk(cpu_ready == 1'b0, "R9 stall held", 64'(cpu_ready), 64'd0);
    chk(mem_wr_req == 1'b1, "R7 head pending", 64'(mem_wr_req), 64'd1);
    hold_wr = 1'b0;
    do_req(1'b1, 16'h6040, 16'h7777, 2'b11, "R9 write after drain");

    // R10 read miss waits for the pending write to the same word
    wait_drained();
    hold_wr = 1'b1;
    do_req(1'b1, 16'h7A10, 16'h5AA5, 2'b11, "R10 posted write");
    fork
      begin
        repeat (12) @(negedge clk);
        chk(mem_rd_req == 1'b0, "R10 fetch blocked", 64'(mem_rd_req), 64'd0);
        hold_wr = 1'b0;
      end
      do_req(1'b0, 16'h7A10, '0, 2'b00, "R10 read sees new data");
    join

    // random mix over a small footprint
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      bit we;
      a = {5'($urandom % 4), 8'($urandom % 8), 3'($urandom % 8)};
      we = ($urandom % 3 == 0);
      do_req(we, a, 16'($urandom), 2'(1 + $urandom % 3), "random");
    end

    wait_drained();
    repeat (4) @(negedge clk);
    chk(exp_wr_q.size() == 0, "R7 all writes drained", 64'(exp_wr_q.size()), 64'd0);
    finish_run();
  end
endmodule